// File: doc/BRIEF.md
# Receive Character Buffer with Error Tags

This block sits between a serial receive shifter and a host. Each character arrives through a single-cycle write strobe. The strobe carries the 8-bit data byte and three per-character error tags, and the buffer keeps all eleven bits in one entry. The host sees the oldest stored entry on a read-only holding port. A read strobe retires that entry, and the next entry's byte and tags show on the port at once.

The buffer runs in one of two modes:

- **Buffered mode.** It holds up to 128 entries. A level mode input picks how the ready interrupt fires: on any stored character, or only once the fill level reaches one of four trigger levels.
- **Single-register mode.** The FIFO enable is low and the buffer acts as a one-entry holding register. It signals ready after each character.

A time-out counter advances on a bit-time tick and keeps a few characters below the trigger level from being stranded. When characters are waiting and no character has been written or read for four word lengths plus twelve bit times, the interrupt fires. A write to a full buffer drops the character and sets a sticky overrun flag. A clear input empties the buffer in one cycle.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset, or one cycle after `fifo_clr` is high, the buffer is empty: `data_ready`=0, `irq`=0, `overrun`=0, and `head_data`/`head_tags` read 0. `fifo_clr` takes priority over a write or read in the same cycle, which are then discarded.
- R2: `head_data`/`head_tags` always show the oldest stored entry, byte and tags together, in write order. A read strobe on a non-empty buffer retires the head, and the next entry shows on the port after that clock edge.
- R3: With `fifo_en`=1 the buffer holds 128 entries. A write while full and without a same-cycle read is dropped, the head is unchanged, and `overrun` goes to 1. `overrun` then stays at 1 until reset or `fifo_clr`.
- R4: With `fifo_en`=0 the capacity is one entry. A second write before a read is dropped and sets `overrun`, and the first character stays at the head.
- R5: `data_ready` is 1 exactly when at least one entry is stored.
- R6: With `fifo_en`=1 and `lvl_mode`=1, the level part of the interrupt is active when the fill count is at least the trigger level. `trig_sel` codes 0, 1, 2 and 3 select 8, 16, 56 and 60 entries.
- R7: With `fifo_en`=0, or with `lvl_mode`=0, the level part of the interrupt is active whenever `data_ready` is 1.
- R8: The time-out counter is zero while the buffer is empty. It restarts on any write strobe or accepted read. Otherwise it counts `bit_tick` cycles. Once it reaches 4·(7+`wlen_code`)+12 ticks (40, 44, 48 or 52), it forces the interrupt until the next restart.
- R9: `irq` is 0 whenever `irq_en` is 0.
- R10: A read strobe on an empty buffer changes nothing. A read and a write in the same cycle on a full buffer are both accepted, without overrun, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_clr | input | 1 | Empties the buffer and clears overrun and time-out state |
| fifo_en | input | 1 | 1: 128-entry buffer; 0: single holding register |
| lvl_mode | input | 1 | 1: ready interrupt at trigger level; 0: per character |
| trig_sel | input | 2 | Trigger level code (8/16/56/60) |
| wlen_code | input | 2 | Word-length code for the time-out length |
| irq_en | input | 1 | Receive interrupt enable |
| bit_tick | input | 1 | One pulse per bit time |
| wr_stb | input | 1 | Character write strobe from the shifter |
| wr_data | input | 8 | Received byte |
| wr_tags | input | 3 | Error tags of the received byte |
| rd_stb | input | 1 | Host read strobe |
| head_data | output | 8 | Byte of the oldest entry (0 when empty) |
| head_tags | output | 3 | Tags of the oldest entry (0 when empty) |
| data_ready | output | 1 | At least one entry stored |
| overrun | output | 1 | Sticky: a character was dropped |
| irq | output | 1 | Receive interrupt |

## Verification
Two collisions can land in the same cycle.

- **Host read against a shifter write.** This matters most when the buffer is full, where the outcome decides between a clean swap and an overrun. The bench fills all 128 entries and then strobes both together. It expects the count unchanged, no overrun, and the old second entry at the head.
- **Restart against a counting tick.** A write or read can arrive with a bit tick in the same cycle. The random phases raise tick, write and read together often. Every cycle, the interrupt is compared with a bench model in which the restart always wins over the tick.

// File: rtl/rx_tag_fifo_pkg.sv
package rx_tag_fifo_pkg;

  // Trigger level for a 2-bit select code, scaled to the buffer depth.
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return depth / 16;
      2'd1:    return depth / 8;
      2'd2:    return (depth * 7) / 16;
      default: return (depth * 15) / 32;
    endcase
  endfunction

  // Time-out length in bit times: four frames (start, data, stop) plus twelve.
  function automatic int unsigned to_limit(input logic [1:0] wlen);
    int unsigned frame_bits;
    frame_bits = 32'd7 + 32'(wlen);
    return 4 * frame_bits + 12;
  endfunction

endpackage

// File: rtl/rtf_store.sv
module rtf_store #(
  parameter int DEPTH = 128,
  parameter int W     = 11,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_ok,
  input  logic             rd_ok,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = (count == '0) ? '0 : mem[rd_ptr];
endmodule

// File: rtl/rtf_timeout.sv
module rtf_timeout #(
  parameter int TO_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            restart,
  input  logic            idle,
  input  logic            tick,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || restart || idle) cnt <= '0;
    else if (tick && cnt < limit)         cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);
endmodule

// File: rtl/rtf_irq.sv
module rtf_irq #(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [CNT_W-1:0] count,
  input  logic             fifo_en,
  input  logic             lvl_mode,
  input  logic [1:0]       trig_sel,
  input  logic             irq_en,
  input  logic             to_expired,
  output logic             level_hit,
  output logic             irq
);
  import rx_tag_fifo_pkg::*;

  logic have_data, ready_src;

  assign have_data = (count != '0);
  assign level_hit = (count >= CNT_W'(trig_level(trig_sel, DEPTH)));
  assign ready_src = have_data && (!fifo_en || !lvl_mode || level_hit);
  assign irq       = irq_en && (ready_src || to_expired);
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_clr,
  input  logic              fifo_en,
  input  logic              lvl_mode,
  input  logic [1:0]        trig_sel,
  input  logic [1:0]        wlen_code,
  input  logic              irq_en,
  input  logic              bit_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tags,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] head_data,
  output logic [TAG_W-1:0]  head_tags,
  output logic              data_ready,
  output logic              overrun,
  output logic              irq
);
  import rx_tag_fifo_pkg::*;

  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;
  localparam int ENT_W = DATA_W + TAG_W;
  localparam int TO_W  = $clog2(to_limit(2'd3) + 1);

  logic [CNT_W-1:0] count;
  logic [ENT_W-1:0] head;
  logic [TO_W-1:0]  to_lim;
  logic             empty, full, wr_ok, rd_ok, drop_evt, to_expired, level_hit, ovr_q;

  // Named internal events, also seen by the bound checker.
  assign empty    = (count == '0);
  assign full     = (count >= (fifo_en ? CNT_W'(DEPTH) : CNT_W'(1)));
  assign rd_ok    = rd_stb && !empty && !fifo_clr;
  assign wr_ok    = wr_stb && !fifo_clr && (!full || rd_ok);
  assign drop_evt = wr_stb && !fifo_clr && !wr_ok;
  assign to_lim   = TO_W'(to_limit(wlen_code));

  rtf_store #(.DEPTH(DEPTH), .W(ENT_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .wr_ok (wr_ok),
    .rd_ok (rd_ok),
    .din   ({wr_tags, wr_data}),
    .head  (head),
    .count (count)
  );

  rtf_timeout #(.TO_W(TO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fifo_clr),
    .restart (wr_stb || rd_ok),
    .idle    (empty),
    .tick    (bit_tick),
    .limit   (to_lim),
    .expired (to_expired)
  );

  rtf_irq #(.DEPTH(DEPTH)) u_irq (
    .count      (count),
    .fifo_en    (fifo_en),
    .lvl_mode   (lvl_mode),
    .trig_sel   (trig_sel),
    .irq_en     (irq_en),
    .to_expired (to_expired),
    .level_hit  (level_hit),
    .irq        (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || fifo_clr) ovr_q <= 1'b0;
    else if (drop_evt)      ovr_q <= 1'b1;
  end

  assign head_data  = head[DATA_W-1:0];
  assign head_tags  = head[ENT_W-1:DATA_W];
  assign data_ready = !empty;
  assign overrun    = ovr_q;
endmodule

// File: rtl/rtf_checker.sv
module rtf_checker #(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_clr,
  input logic             fifo_en,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic             irq_en,
  input logic             data_ready,
  input logic             overrun,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic             wr_ok,
  input logic             rd_ok,
  input logic             drop_evt,
  input logic             to_expired
);
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (count == '0 && !overrun && !to_expired)); // R1
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !fifo_clr) |=> overrun); // R3
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (overrun && $stable(count))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R3
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && count == CNT_W'(1) && wr_stb && !rd_stb && !fifo_clr) |-> drop_evt); // R4
  AST_READY_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !rd_ok) |=> data_ready); // R5
  AST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> !to_expired); // R8
  AST_TO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !to_expired); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R9
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !data_ready) |-> !rd_ok); // R10
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && wr_stb && !fifo_clr) |-> wr_ok); // R10
endmodule

bind rx_tag_fifo rtf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_clr   (fifo_clr),
  .fifo_en    (fifo_en),
  .wr_stb     (wr_stb),
  .rd_stb     (rd_stb),
  .irq_en     (irq_en),
  .data_ready (data_ready),
  .overrun    (overrun),
  .irq        (irq),
  .count      (count),
  .wr_ok      (wr_ok),
  .rd_ok      (rd_ok),
  .drop_evt   (drop_evt),
  .to_expired (to_expired)
);

// File: tb/rx_tag_fifo_test.sv
`timescale 1ns/1ps
module rx_tag_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_clr = 0, fifo_en = 1, lvl_mode = 0, irq_en = 1, bit_tick = 0;
  logic wr_stb = 0, rd_stb = 0;
  logic [1:0] trig_sel = 0, wlen_code = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_tags = 0;
  logic [7:0] head_data;
  logic [2:0] head_tags;
  logic data_ready, overrun, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  // Bench model
  logic [10:0] q[$];
  bit m_ovr = 0;
  int m_to = 0;

  always #2.5 clk = ~clk;

  rx_tag_fifo uut (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .fifo_en(fifo_en),
    .lvl_mode(lvl_mode), .trig_sel(trig_sel), .wlen_code(wlen_code),
    .irq_en(irq_en), .bit_tick(bit_tick), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_tags(wr_tags), .rd_stb(rd_stb), .head_data(head_data),
    .head_tags(head_tags), .data_ready(data_ready), .overrun(overrun), .irq(irq)
  );

  function automatic int exp_trig(input logic [1:0] s);
    case (s)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 56;
      default: return 60;
    endcase
  endfunction

  function automatic int exp_limit(input logic [1:0] w);
    case (w)
      2'd0: return 40;
      2'd1: return 44;
      2'd2: return 48;
      default: return 52;
    endcase
  endfunction

  function automatic bit exp_irq();
    int n;
    bit lvl;
    n = q.size();
    lvl = (n > 0) && (!fifo_en || !lvl_mode || n >= exp_trig(trig_sel));
    return irq_en && (lvl || m_to >= exp_limit(wlen_code));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit rd_ok, wr_ok, empty_before;
    int cap;
    if (fifo_clr) begin
      q.delete();
      m_ovr = 0;
      m_to = 0;
      return;
    end
    empty_before = (q.size() == 0);
    cap = fifo_en ? 128 : 1;
    rd_ok = rd_stb && !empty_before;
    wr_ok = wr_stb && (q.size() < cap || rd_ok);
    if (wr_stb && !wr_ok) m_ovr = 1;
    if (rd_ok) void'(q.pop_front());
    if (wr_ok) q.push_back({wr_tags, wr_data});
    if (wr_stb || rd_ok || empty_before) m_to = 0;
    else if (bit_tick && m_to < exp_limit(wlen_code)) m_to++;
  endtask

  task automatic compare_all();
    logic [10:0] h;
    h = (q.size() > 0) ? q[0] : 11'd0;
    chk("R2 head_data", int'(head_data), int'(h[7:0]));
    chk("R2 head_tags", int'(head_tags), int'(h[10:8]));
    chk("R5 data_ready", int'(data_ready), int'(q.size() > 0));
    chk("R3 overrun", int'(overrun), int'(m_ovr));
    chk("R6/R7/R8/R9 irq", int'(irq), int'(exp_irq()));
  endtask

  // Apply the current inputs at one edge, then compare and release strobes.
  task automatic run_cycle();
    @(posedge clk);
    model_step();
    #1;
    compare_all();
    @(negedge clk);
    wr_stb = 0; rd_stb = 0; bit_tick = 0; fifo_clr = 0;
  endtask

  task automatic do_write(input logic [7:0] d, input logic [2:0] t);
    wr_stb = 1; wr_data = d; wr_tags = t;
    run_cycle();
  endtask

  task automatic do_read();
    rd_stb = 1;
    run_cycle();
  endtask

  task automatic do_clear();
    fifo_clr = 1;
    run_cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 ready after reset", int'(data_ready), 0);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 overrun after reset", int'(overrun), 0);
    chk("R1 head after reset", int'({head_tags, head_data}), 0);

    // R2: order with tags
    fifo_en = 1; lvl_mode = 0;
    do_write(8'hA1, 3'd5);
    do_write(8'hB2, 3'd2);
    do_write(8'hC3, 3'd7);
    chk("R2 first head", int'({head_tags, head_data}), int'({3'd5, 8'hA1}));
    do_read();
    chk("R2 next head after read", int'({head_tags, head_data}), int'({3'd2, 8'hB2}));

    // R1: clear wins over simultaneous write
    fifo_clr = 1; wr_stb = 1; wr_data = 8'h55;
    run_cycle();
    chk("R1 clear empties", int'(data_ready), 0);

    // R10: read on empty
    do_read();
    chk("R10 empty read", int'(data_ready), 0);

    // R6: trigger level 16
    lvl_mode = 1; trig_sel = 2'd1;
    for (int i = 0; i < 15; i++) do_write(8'(i), 3'd0);
    chk("R6 below level", int'(irq), 0);
    do_write(8'hEE, 3'd1);
    chk("R6 at level", int'(irq), 1);

    // R9: gated
    irq_en = 0;
    run_cycle();
    chk("R9 gated", int'(irq), 0);
    irq_en = 1;

    // R8: time-out with one character, level 8, wlen 0 -> 40 ticks
    do_clear();
    trig_sel = 2'd0; wlen_code = 2'd0;
    do_write(8'h3C, 3'd4);
    for (int i = 0; i < 39; i++) begin bit_tick = 1; run_cycle(); end
    chk("R8 before limit", int'(irq), 0);
    bit_tick = 1; run_cycle();
    chk("R8 at limit", int'(irq), 1);
    do_write(8'h3D, 3'd0);
    chk("R8 restart on write", int'(irq), 0);

    // R3: full buffer and drop
    do_clear();
    lvl_mode = 0;
    for (int i = 0; i < 128; i++) do_write(8'(i + 1), 3'(i));
    chk("R3 full no overrun", int'(overrun), 0);
    // R10: swap at full
    rd_stb = 1; wr_stb = 1; wr_data = 8'h99; wr_tags = 3'd3;
    run_cycle();
    chk("R10 swap no overrun", int'(overrun), 0);
    chk("R10 swap head advanced", int'(head_data), 2);
    do_write(8'h77, 3'd6);
    chk("R3 drop sets overrun", int'(overrun), 1);
    chk("R3 head unchanged", int'(head_data), 2);
    do_read();
    chk("R3 overrun sticky", int'(overrun), 1);

    // R4 and R7: single register mode
    do_clear();
    fifo_en = 0; lvl_mode = 1; trig_sel = 2'd3;
    do_write(8'h11, 3'd1);
    chk("R7 single mode irq per char", int'(irq), 1);
    do_write(8'h22, 3'd2);
    chk("R4 second write dropped", int'(head_data), 8'h11);
    chk("R4 overrun", int'(overrun), 1);

    // Random phases with every-cycle comparison against the model
    for (int ph = 0; ph < 12; ph++) begin
      int pw, pr;
      fifo_en = (ph % 4) != 3;
      lvl_mode = $urandom_range(0, 1);
      trig_sel = 2'($urandom_range(0, 3));
      wlen_code = 2'($urandom_range(0, 3));
      irq_en = ($urandom_range(0, 5) != 0);
      pw = (ph % 3 == 0) ? 70 : ((ph % 3 == 1) ? 40 : 5);
      pr = (ph % 3 == 0) ? 20 : ((ph % 3 == 1) ? 40 : 3);
      for (int c = 0; c < 400; c++) begin
        wr_stb = ($urandom_range(0, 99) < pw);
        rd_stb = ($urandom_range(0, 99) < pr);
        bit_tick = ($urandom_range(0, 99) < 60);
        fifo_clr = ($urandom_range(0, 299) == 0);
        wr_data = 8'($urandom);
        wr_tags = 3'($urandom);
        run_cycle();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule